// File: doc/BRIEF.md
# Raster Line and Frame Timing Generator

This block produces the beam position for a tile-based video processor and decodes it into display regions. A horizontal counter steps through 342 internal cycles per line. A vertical counter steps through the lines of one frame, and the frame length depends on a standard-select input: 262 lines for the 60 Hz standard and 313 lines for the 50 Hz standard. On every cycle exactly one of three horizontal regions is flagged: pixel, border or blanking. A separate vertical sync flag is raised for three lines of each frame.

Two interrupt sources share one request line. The frame flag is set when the beam reaches column 4 of row 193. The scanline flag comes from an 8-bit down-counter. This counter steps once at the end of each active line. When it underflows it reloads from a programmable target and sets the flag, and on every non-active line it reloads without setting anything. Software reads the status with a one-cycle strobe, and that strobe clears both flags.

Top module: `raster_timing_gen`

## Requirements
- R1: `col` counts 0 to 341 and then returns to 0. `row` increases by one on the cycle in which `col` returns to 0.
- R2: When `std_50hz`=0, `row` goes back to 0 after row 261. When `std_50hz`=1, `row` goes back to 0 after row 312, so row 262 is reached.
- R3: Exactly one of `pixel_on`, `border_on` and `hblank_on` is high on every cycle. `hblank_on` is high exactly for columns 15 to 72 on every row.
- R4: `pixel_on` is high when all of these hold: the row is below 192, the column is at least 86, the column is at least `first_col`, and the column is below `stop_col`. At every other position outside columns 15 to 72, `border_on` is high.
- R5: `vsync_on` is high exactly for rows 227, 228 and 229.
- R6: The region outputs describe the same position that `col` and `row` show in that cycle. They change on the same clock edge as the counters.
- R7: `frame_flag` is high from the cycle after the beam sits at column 4 of row 193.
- R8: The scanline target resets to 0xFF, and so does the counter. On a write strobe the target takes `line_tgt_data`. At column 341 of an active row (row below 192), a counter at 0 reloads from the target and sets `line_flag` in the next cycle. A counter above 0 decrements instead. At column 341 of any other row, the counter reloads from the target. A reload in the same cycle as a write uses the old target.
- R9: `irq` = (`frame_flag` AND `frame_irq_en`) OR (`line_flag` AND `line_irq_en`).
- R10: A `status_rd` pulse clears both flags in the next cycle. A set event in the same cycle wins over the clear.
- R11: After reset, `col`=0, `row`=0, both flags are low, `irq` is low and `border_on` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal timing clock |
| rst | input | 1 | Synchronous active-high reset |
| std_50hz | input | 1 | 1 selects 313-line frames, 0 selects 262-line frames |
| first_col | input | 9 | First column that may show pixels |
| stop_col | input | 9 | First column after the pixel span |
| frame_irq_en | input | 1 | Lets the frame flag drive `irq` |
| line_irq_en | input | 1 | Lets the scanline flag drive `irq` |
| line_tgt_wr | input | 1 | Write strobe for the scanline reload target |
| line_tgt_data | input | 8 | New scanline reload target |
| status_rd | input | 1 | Status read strobe, clears both flags |
| col | output | 9 | Current cycle within the line |
| row | output | 9 | Current line within the frame |
| pixel_on | output | 1 | Position lies in the pixel span |
| border_on | output | 1 | Position shows border colour |
| hblank_on | output | 1 | Position lies in horizontal blanking and sync |
| vsync_on | output | 1 | Row lies in vertical sync |
| frame_flag | output | 1 | Frame-end interrupt pending |
| line_flag | output | 1 | Scanline interrupt pending |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench checks the row-count switch at the 261-to-0 wrap and again after the 50 Hz standard is selected. A design with the wrong limit would wrap too early or run past the wrap. It checks a status read issued in the same cycle as the frame-end event. A design that gives the clear priority would lose that interrupt. With a target of 0 and with small random targets, it checks the scanline counter on the last active line and on the non-active lines. An off-by-one reload, or a counter that also steps during blank lines, would move the flag to the wrong line. Random changes to the pixel window would expose a decode taken from the position one cycle stale, because the regions would then lag the counters by one cycle.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

    typedef struct packed {
        logic pixel;
        logic border;
        logic hblank;
        logic vsync;
    } region_t;

    function automatic logic in_span(input int v, input int lo, input int hi);
        return (v >= lo) && (v <= hi);
    endfunction

endpackage

// File: rtl/rtg_raster_cnt.sv
module rtg_raster_cnt #(
    parameter int LINE_CYCLES = 342,
    parameter int LINES_STD0  = 262,
    parameter int LINES_STD1  = 313,
    parameter int COL_W       = 9,
    parameter int ROW_W       = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             std_sel,
    output logic [COL_W-1:0] col,
    output logic [ROW_W-1:0] row,
    output logic [COL_W-1:0] col_nxt,
    output logic [ROW_W-1:0] row_nxt,
    output logic             line_end
);
    localparam logic [COL_W-1:0] COL_LAST  = COL_W'(LINE_CYCLES - 1);
    localparam logic [ROW_W-1:0] ROW_LAST0 = ROW_W'(LINES_STD0 - 1);
    localparam logic [ROW_W-1:0] ROW_LAST1 = ROW_W'(LINES_STD1 - 1);

    logic [ROW_W-1:0] row_last;

    always_comb begin
        line_end = (col == COL_LAST);
        row_last = std_sel ? ROW_LAST1 : ROW_LAST0;
        col_nxt  = line_end ? '0 : col + 1'b1;
        if (!line_end)
            row_nxt = row;
        else if (row >= row_last)
            row_nxt = '0;
        else
            row_nxt = row + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            col <= '0;
            row <= '0;
        end else begin
            col <= col_nxt;
            row <= row_nxt;
        end
    end
endmodule

// File: rtl/rtg_region.sv
module rtg_region
    import rtg_pkg::*;
#(
    parameter int COL_W        = 9,
    parameter int ROW_W        = 9,
    parameter int HB_FIRST     = 15,
    parameter int HB_LAST      = 72,
    parameter int PIX_MIN_COL  = 86,
    parameter int ACTIVE_LINES = 192,
    parameter int VS_FIRST     = 227,
    parameter int VS_LINES     = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [COL_W-1:0] col_nxt,
    input  logic [ROW_W-1:0] row_nxt,
    input  logic [COL_W-1:0] first_col,
    input  logic [COL_W-1:0] stop_col,
    output region_t          rgn
);
    localparam int VS_LAST = VS_FIRST + VS_LINES - 1;

    int      c_i;
    int      r_i;
    region_t rgn_d;

    always_comb begin
        c_i = int'(col_nxt);
        r_i = int'(row_nxt);
        rgn_d.hblank = in_span(c_i, HB_FIRST, HB_LAST);
        rgn_d.pixel  = (r_i < ACTIVE_LINES) && (c_i >= PIX_MIN_COL)
                     && (c_i >= int'(first_col)) && (c_i < int'(stop_col));
        rgn_d.border = !rgn_d.hblank && !rgn_d.pixel;
        rgn_d.vsync  = in_span(r_i, VS_FIRST, VS_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst)
            rgn <= '{pixel: 1'b0, border: 1'b1, hblank: 1'b0, vsync: 1'b0};
        else
            rgn <= rgn_d;
    end
endmodule

// File: rtl/rtg_irq.sv
module rtg_irq #(
    parameter int COL_W        = 9,
    parameter int ROW_W        = 9,
    parameter int CNT_W        = 8,
    parameter int ACTIVE_LINES = 192,
    parameter int FIRQ_ROW     = 193,
    parameter int FIRQ_COL     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [COL_W-1:0] col,
    input  logic [ROW_W-1:0] row,
    input  logic             line_end,
    input  logic             status_rd,
    input  logic             tgt_wr,
    input  logic [CNT_W-1:0] tgt_data,
    output logic             frame_flag,
    output logic             line_flag
);
    logic [CNT_W-1:0] target;
    logic [CNT_W-1:0] count;
    logic             frame_hit;
    logic             active_row;
    logic             underflow;

    always_comb begin
        frame_hit  = (col == COL_W'(FIRQ_COL)) && (row == ROW_W'(FIRQ_ROW));
        active_row = (row < ROW_W'(ACTIVE_LINES));
        underflow  = line_end && active_row && (count == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            target     <= '1;
            count      <= '1;
            frame_flag <= 1'b0;
            line_flag  <= 1'b0;
        end else begin
            if (tgt_wr)
                target <= tgt_data;
            if (line_end)
                count <= (!active_row || underflow) ? target : count - 1'b1;
            if (frame_hit)
                frame_flag <= 1'b1;
            else if (status_rd)
                frame_flag <= 1'b0;
            if (underflow)
                line_flag <= 1'b1;
            else if (status_rd)
                line_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int LINE_CYCLES  = 342,
    parameter int LINES_STD0   = 262,
    parameter int LINES_STD1   = 313,
    parameter int ACTIVE_LINES = 192,
    parameter int HB_FIRST     = 15,
    parameter int HB_LAST      = 72,
    parameter int PIX_MIN_COL  = 86,
    parameter int VS_FIRST     = 227,
    parameter int VS_LINES     = 3,
    parameter int FIRQ_ROW     = 193,
    parameter int FIRQ_COL     = 4,
    parameter int CNT_W        = 8,
    localparam int COL_W = $clog2(LINE_CYCLES),
    localparam int ROW_W = $clog2(LINES_STD1 > LINES_STD0 ? LINES_STD1 : LINES_STD0)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             std_50hz,
    input  logic [COL_W-1:0] first_col,
    input  logic [COL_W-1:0] stop_col,
    input  logic             frame_irq_en,
    input  logic             line_irq_en,
    input  logic             line_tgt_wr,
    input  logic [CNT_W-1:0] line_tgt_data,
    input  logic             status_rd,
    output logic [COL_W-1:0] col,
    output logic [ROW_W-1:0] row,
    output logic             pixel_on,
    output logic             border_on,
    output logic             hblank_on,
    output logic             vsync_on,
    output logic             frame_flag,
    output logic             line_flag,
    output logic             irq
);
    logic [COL_W-1:0] col_nxt;
    logic [ROW_W-1:0] row_nxt;
    logic             line_end;
    region_t          rgn;

    rtg_raster_cnt #(
        .LINE_CYCLES(LINE_CYCLES), .LINES_STD0(LINES_STD0), .LINES_STD1(LINES_STD1),
        .COL_W(COL_W), .ROW_W(ROW_W)
    ) cnt_i (
        .clk(clk), .rst(rst), .std_sel(std_50hz),
        .col(col), .row(row), .col_nxt(col_nxt), .row_nxt(row_nxt),
        .line_end(line_end)
    );

    rtg_region #(
        .COL_W(COL_W), .ROW_W(ROW_W), .HB_FIRST(HB_FIRST), .HB_LAST(HB_LAST),
        .PIX_MIN_COL(PIX_MIN_COL), .ACTIVE_LINES(ACTIVE_LINES),
        .VS_FIRST(VS_FIRST), .VS_LINES(VS_LINES)
    ) rgn_i (
        .clk(clk), .rst(rst), .col_nxt(col_nxt), .row_nxt(row_nxt),
        .first_col(first_col), .stop_col(stop_col), .rgn(rgn)
    );

    rtg_irq #(
        .COL_W(COL_W), .ROW_W(ROW_W), .CNT_W(CNT_W), .ACTIVE_LINES(ACTIVE_LINES),
        .FIRQ_ROW(FIRQ_ROW), .FIRQ_COL(FIRQ_COL)
    ) irq_i (
        .clk(clk), .rst(rst), .col(col), .row(row), .line_end(line_end),
        .status_rd(status_rd), .tgt_wr(line_tgt_wr), .tgt_data(line_tgt_data),
        .frame_flag(frame_flag), .line_flag(line_flag)
    );

    always_comb begin
        pixel_on  = rgn.pixel;
        border_on = rgn.border;
        hblank_on = rgn.hblank;
        vsync_on  = rgn.vsync;
        irq       = (frame_flag && frame_irq_en) || (line_flag && line_irq_en);
    end
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker #(
    parameter int LINE_CYCLES  = 342,
    parameter int ACTIVE_LINES = 192,
    parameter int VS_FIRST     = 227,
    parameter int VS_LINES     = 3,
    parameter int FIRQ_ROW     = 193,
    parameter int FIRQ_COL     = 4,
    parameter int COL_W        = 9,
    parameter int ROW_W        = 9
) (
    input logic             clk,
    input logic             rst,
    input logic [COL_W-1:0] col,
    input logic [ROW_W-1:0] row,
    input logic             pixel_on,
    input logic             border_on,
    input logic             hblank_on,
    input logic             vsync_on,
    input logic             frame_flag,
    input logic             line_flag,
    input logic             status_rd,
    input logic             irq
);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(LINE_CYCLES - 1);

    logic fpos;
    assign fpos = (col == COL_W'(FIRQ_COL)) && (row == ROW_W'(FIRQ_ROW));

    p_col_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (col == COL_LAST) |=> (col == '0));

    p_col_step_r1: assert property (@(posedge clk) disable iff (rst)
        (col != COL_LAST) |=> (col == COL_W'($past(col) + 1'b1)));

    p_one_region_r3: assert property (@(posedge clk) disable iff (rst)
        $countones({pixel_on, border_on, hblank_on}) == 1);

    p_pixel_rows_r4: assert property (@(posedge clk) disable iff (rst)
        pixel_on |-> (row < ROW_W'(ACTIVE_LINES)));

    p_vsync_rows_r5: assert property (@(posedge clk) disable iff (rst)
        vsync_on |-> ((row >= ROW_W'(VS_FIRST)) && (row < ROW_W'(VS_FIRST + VS_LINES))));

    p_frame_set_r7: assert property (@(posedge clk) disable iff (rst)
        fpos |=> frame_flag);

    p_blank_line_r8: assert property (@(posedge clk) disable iff (rst)
        ((col == COL_LAST) && (row >= ROW_W'(ACTIVE_LINES))) |=> !$rose(line_flag));

    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (!frame_flag && !line_flag) |-> !irq);

    p_read_clears_r10: assert property (@(posedge clk) disable iff (rst)
        (status_rd && !fpos) |=> !frame_flag);
endmodule

bind raster_timing_gen rtg_checker #(
    .LINE_CYCLES(LINE_CYCLES), .ACTIVE_LINES(ACTIVE_LINES), .VS_FIRST(VS_FIRST),
    .VS_LINES(VS_LINES), .FIRQ_ROW(FIRQ_ROW), .FIRQ_COL(FIRQ_COL),
    .COL_W(COL_W), .ROW_W(ROW_W)
) chk_i (
    .clk(clk), .rst(rst), .col(col), .row(row), .pixel_on(pixel_on),
    .border_on(border_on), .hblank_on(hblank_on), .vsync_on(vsync_on),
    .frame_flag(frame_flag), .line_flag(line_flag), .status_rd(status_rd), .irq(irq)
);

// File: tb/raster_timing_gen_tb.sv
`timescale 1ns/1ps
module raster_timing_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       std_50hz = 1'b0;
    logic [8:0] first_col = 9'd94;
    logic [8:0] stop_col = 9'd334;
    logic       frame_irq_en = 1'b1;
    logic       line_irq_en = 1'b1;
    logic       line_tgt_wr = 1'b0;
    logic [7:0] line_tgt_data = 8'd0;
    logic       status_rd = 1'b0;
    logic [8:0] col;
    logic [8:0] row;
    logic       pixel_on, border_on, hblank_on, vsync_on;
    logic       frame_flag, line_flag, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    raster_timing_gen dut_i (
        .clk(clk), .rst(rst), .std_50hz(std_50hz), .first_col(first_col),
        .stop_col(stop_col), .frame_irq_en(frame_irq_en), .line_irq_en(line_irq_en),
        .line_tgt_wr(line_tgt_wr), .line_tgt_data(line_tgt_data), .status_rd(status_rd),
        .col(col), .row(row), .pixel_on(pixel_on), .border_on(border_on),
        .hblank_on(hblank_on), .vsync_on(vsync_on), .frame_flag(frame_flag),
        .line_flag(line_flag), .irq(irq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d (col=%0d row=%0d)",
                     req, what, act, exp, col, row);
        end
    endtask

    function automatic bit exp_hb(input int c);
        return (c >= 15) && (c <= 72);
    endfunction

    function automatic bit exp_px(input int c, input int r, input int f, input int s);
        return (r < 192) && (c >= 86) && (c >= f) && (c < s);
    endfunction

    function automatic bit exp_vs(input int r);
        return (r >= 227) && (r <= 229);
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int  ec, er, pc, pr;
        int  m_tgt, m_cnt;
        bit  m_ff, m_lf;
        int  phase;
        int  tail;
        bit  rd_done;
        void'($urandom(32'h1234_abcd));
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        // R11 reset state
        chk("R11", "col", int'(col), 0);
        chk("R11", "row", int'(row), 0);
        chk("R11", "frame_flag", int'(frame_flag), 0);
        chk("R11", "line_flag", int'(line_flag), 0);
        chk("R11", "irq", int'(irq), 0);
        chk("R11", "border_on", int'(border_on), 1);
        ec = 0; er = 0; pc = 0; pr = 0;
        m_tgt = 255; m_cnt = 255; m_ff = 0; m_lf = 0;
        phase = 0; tail = 0; rd_done = 0;
        // directed: target 0 so every active line raises the scanline flag
        line_tgt_wr = 1'b1; line_tgt_data = 8'd0;
        while (1) begin
            bit lev, fev;
            @(posedge clk);
            #1;
            // reference model update for the edge just passed, using held inputs
            fev = (pc == 4) && (pr == 193);
            lev = 0;
            if (pc == 341) begin
                if (pr < 192) begin
                    if (m_cnt == 0) begin m_cnt = m_tgt; lev = 1; end
                    else m_cnt = m_cnt - 1;
                end else m_cnt = m_tgt;
            end
            if (line_tgt_wr) m_tgt = int'(line_tgt_data);
            if (fev) m_ff = 1; else if (status_rd) m_ff = 0;
            if (lev) m_lf = 1; else if (status_rd) m_lf = 0;
            if (pc == 341) begin
                ec = 0;
                er = (pr >= (std_50hz ? 312 : 261)) ? 0 : pr + 1;
            end else ec = pc + 1;

            chk("R1", "col", int'(col), ec);
            chk("R1,R2", "row", int'(row), er);
            chk("R3", "hblank_on", int'(hblank_on), int'(exp_hb(ec)));
            chk("R4,R6", "pixel_on", int'(pixel_on),
                int'(exp_px(ec, er, int'(first_col), int'(stop_col))));
            chk("R4,R6", "border_on", int'(border_on),
                int'(!exp_hb(ec) && !exp_px(ec, er, int'(first_col), int'(stop_col))));
            chk("R5", "vsync_on", int'(vsync_on), int'(exp_vs(er)));
            chk(fev ? "R7" : "R10", "frame_flag", int'(frame_flag), int'(m_ff));
            chk("R8", "line_flag", int'(line_flag), int'(m_lf));
            chk("R9", "irq", int'(irq), int'((m_ff && frame_irq_en) || (m_lf && line_irq_en)));
            if (pc == 341 && pr == 261 && phase == 0)
                chk("R2", "wrap at 60 Hz", int'(row), 0);
            if (fev && status_rd)
                chk("R10", "set wins over read", int'(frame_flag), 1);

            pc = ec; pr = er;

            // next stimulus, driven away from the clock edge
            line_tgt_wr = 1'b0;
            status_rd   = 1'b0;
            if ($urandom % 300 == 0) status_rd = 1'b1;
            if ($urandom % 2000 == 0) begin
                line_tgt_wr = 1'b1;
                line_tgt_data = 8'($urandom % 4);
            end
            if ($urandom % 1000 == 0) frame_irq_en = ~frame_irq_en;
            if ($urandom % 1000 == 0) line_irq_en = ~line_irq_en;
            if ($urandom % 3000 == 0) begin
                first_col = 9'(80 + $urandom % 41);
                stop_col  = 9'(300 + $urandom % 43);
            end
            if (pc == 4 && pr == 193 && !rd_done) begin
                status_rd = 1'b1;   // directed R10 collision with the frame event
                rd_done = 1;
            end

            if (phase == 0 && pc == 0 && pr == 0 && n_chk > 2000) begin
                std_50hz = 1'b1;
                phase = 1;
            end else if (phase == 1 && pr == 262) begin
                chk("R2", "row beyond 261 at 50 Hz", int'(row), 262);
                phase = 2;
            end else if (phase == 2) begin
                tail++;
                if (tail > 400) break;
            end
        end
        done = 1;
        summary();
        $finish;
    end
endmodule